// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Watchdog Mode

This block is a single programmable interval timer clocked from the bus clock. A prescaler divides the clock and a period counter counts the prescaled ticks down. When both reach the end of their range, the period has expired. In timer use, an expiry sets a sticky event flag. The flag can raise an interrupt. The timer either stops after one expiry or reloads and repeats.

The same counter can act as a watchdog. In that mode an expiry does not set the event flag. Instead it emits a one-cycle reset request and halts the counter. Software keeps the watchdog from firing by writing a key byte, which restarts the period. Software programs the block through a word-addressed register port with byte enables. Reads are combinational. There is no read strobe.

Top module: `prescaled_wdog_timer`

## Requirements
- R1: After reset, the mode, count and status registers read as zero, and both `irq` and `wdt_reset` are low.
- R2: Registers are word addressed. Address 0 is mode: bit 8 is interrupt enable, bit 10 is continuous, bit 12 is run, bit 15 is watchdog, and all other bits read zero. The mode bits are written only when byte enable 1 is set. Address 1 is count: bits 31:16 hold the prescaler and bits 15:0 hold the period, each byte written under its own enable. Address 2 is status. Address 3 reads zero.
- R3: While run is set, the period expires P×C clock edges after the edge that loaded the counters. P is the prescaler field and C is the period field, and a field value of 0 counts as 65536.
- R4: In one-shot mode (continuous clear), an expiry sets status bit 0 and clears the run bit in the same edge.
- R5: In continuous mode, the counters reload at expiry. The flag is set again every P×C edges while run stays set.
- R6: A write to the count register, or a mode write that changes run from 0 to 1, reloads both counters from the count value being written. When such a reload falls on an expiry edge, the reload wins and the expiry is dropped.
- R7: Status bit 0 is cleared by a write to address 2 with byte enable 0 and data bit 0 set. If an expiry lands on the same edge, the flag stays set. Status bits 3:1 read zero.
- R8: `irq` is high exactly when status bit 0 and the interrupt-enable bit are both set.
- R9: In watchdog mode an expiry sets no status flag. It drives `wdt_reset` high for exactly one cycle, starting at the expiry edge, and it clears the run bit.
- R10: A mode write with byte enable 3 set and byte 3 equal to 0xA5 restarts both counters, but only while watchdog and run are both set. A key write in any other state, or any other byte-3 value, has no effect on the counters.
- R11: Clearing run freezes the counters, and no expiry occurs while run is clear. Setting run again starts a full new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, which also drives the counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Interrupt request (flag and interrupt enable) |
| wdt_reset | output | 1 | One-cycle reset request on a watchdog expiry |

## Verification
The hardest situation to reach is a register write that lands on the exact edge where the period expires. On that edge the reload has to beat the expiry, and a flag clear has to lose to a new flag set. The stimulus sweeps the write offset one cycle at a time across a short continuous period, so that at least one write of each kind meets an expiry edge. A reference model that advances once per clock decides the expected outcome on every edge. The 65536 encodings for a zero prescaler and a zero period are reached by running each one to a full one-shot expiry.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned BE_W  = BUS_W / 8;

  // word addresses
  localparam int unsigned ADR_MODE  = 0;
  localparam int unsigned ADR_COUNT = 1;
  localparam int unsigned ADR_STAT  = 2;

  // mode bit positions (all within one byte lane)
  localparam int unsigned B_IRQEN = 8;
  localparam int unsigned B_CONT  = 10;
  localparam int unsigned B_RUN   = 12;
  localparam int unsigned B_WDOG  = 15;
  localparam int unsigned MODE_LANE = B_IRQEN / 8;

  // watchdog restart key
  localparam int unsigned KEY_LANE    = 3;
  localparam logic [7:0]  RESTART_KEY = 8'hA5;

  typedef struct packed {
    logic wdog;
    logic run;
    logic cont;
    logic irq_en;
  } mode_t;
endpackage

// File: rtl/pwt_downcnt.sv
module pwt_downcnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] load_val,
  output logic         at_one
);
  // a value of 0 wraps to all ones on the next step, giving 2**W steps
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = load | step;
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign at_one = (cnt_q == W'(1));
endmodule

// File: rtl/pwt_regs.sv
module pwt_regs
  import pwt_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              expire_evt,
  input  logic              hw_stop,
  output mode_t             mode,
  output logic [CW-1:0]     cnt_nxt,
  output logic              flag,
  output logic              reload,
  output logic [BUS_W-1:0]  rdata
);
  mode_t           mode_q, mode_w, mode_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            flag_q, flag_d;
  logic            sel_mode, sel_cnt, sel_stat, kick, clr_flag;
  logic [BUS_W-1:0] wide;

  always_comb begin
    sel_mode = we && (addr == ADDR_W'(ADR_MODE));
    sel_cnt  = we && (addr == ADDR_W'(ADR_COUNT));
    sel_stat = we && (addr == ADDR_W'(ADR_STAT));
  end

  // count register with per-lane writes
  always_comb begin
    wide = BUS_W'(cnt_q);
    for (int b = 0; b < int'(BE_W); b++) begin
      if (sel_cnt && be[b]) wide[8*b +: 8] = wdata[8*b +: 8];
    end
    cnt_d = wide[CW-1:0];
  end

  // software view of the next mode, and reload sources
  always_comb begin
    mode_w = mode_q;
    if (sel_mode && be[MODE_LANE]) begin
      mode_w.wdog   = wdata[B_WDOG];
      mode_w.run    = wdata[B_RUN];
      mode_w.cont   = wdata[B_CONT];
      mode_w.irq_en = wdata[B_IRQEN];
    end
    kick   = sel_mode && be[KEY_LANE] && (wdata[8*KEY_LANE +: 8] == RESTART_KEY)
             && mode_q.wdog && mode_q.run;
    reload = sel_cnt || (mode_w.run && !mode_q.run) || kick;
  end

  // hardware stop overrides the software write
  always_comb begin
    mode_d = mode_w;
    if (hw_stop) mode_d.run = 1'b0;
  end

  always_comb begin
    clr_flag = sel_stat && be[0] && wdata[0];
    flag_d   = (flag_q && !clr_flag) || expire_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (sel_cnt) cnt_q <= cnt_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_W'(ADR_MODE): begin
        rdata[B_WDOG]  = mode_q.wdog;
        rdata[B_RUN]   = mode_q.run;
        rdata[B_CONT]  = mode_q.cont;
        rdata[B_IRQEN] = mode_q.irq_en;
      end
      ADDR_W'(ADR_COUNT): rdata = BUS_W'(cnt_q);
      ADDR_W'(ADR_STAT):  rdata[0] = flag_q;
      default:            rdata = '0;
    endcase
  end

  assign mode    = mode_q;
  assign cnt_nxt = cnt_d;
  assign flag    = flag_q;
endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
  import pwt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode,
  input  logic  reload,
  input  logic  pre_one,
  input  logic  cnt_one,
  output logic  pre_load,
  output logic  pre_step,
  output logic  cnt_load,
  output logic  cnt_step,
  output logic  expire_evt,
  output logic  hw_stop,
  output logic  wdt_pulse
);
  logic tick, expire, expire_eff, wdt_d, wdt_q;

  always_comb begin
    tick       = mode.run && pre_one;
    expire     = tick && cnt_one;
    expire_eff = expire && !reload;
    pre_step   = mode.run;
    pre_load   = reload || tick;
    cnt_step   = tick;
    cnt_load   = reload || expire;
    expire_evt = expire_eff && !mode.wdog;
    hw_stop    = expire_eff && (mode.wdog || !mode.cont);
    wdt_d      = expire_eff && mode.wdog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_q <= 1'b0;
    else        wdt_q <= wdt_d;
  end

  assign wdt_pulse = wdt_q;
endmodule

// File: rtl/prescaled_wdog_timer.sv
module prescaled_wdog_timer
  import pwt_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned PRE_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              wdt_reset
);
  localparam int unsigned CW = PRE_W + CNT_W;

  mode_t          mode_s;
  logic [CW-1:0]  cnt_nxt;
  logic           flag_s, reload_s, expire_evt, hw_stop;
  logic           pre_load, pre_step, pre_one;
  logic           cnt_load, cnt_step, cnt_one;

  pwt_regs #(.ADDR_W(ADDR_W), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .be(bus_be),
    .wdata(bus_wdata), .expire_evt(expire_evt), .hw_stop(hw_stop),
    .mode(mode_s), .cnt_nxt(cnt_nxt), .flag(flag_s), .reload(reload_s),
    .rdata(bus_rdata)
  );

  pwt_downcnt #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .load(pre_load), .step(pre_step),
    .load_val(cnt_nxt[CW-1 -: PRE_W]), .at_one(pre_one)
  );

  pwt_downcnt #(.W(CNT_W)) u_per (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .step(cnt_step),
    .load_val(cnt_nxt[CNT_W-1:0]), .at_one(cnt_one)
  );

  pwt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode_s), .reload(reload_s),
    .pre_one(pre_one), .cnt_one(cnt_one), .pre_load(pre_load),
    .pre_step(pre_step), .cnt_load(cnt_load), .cnt_step(cnt_step),
    .expire_evt(expire_evt), .hw_stop(hw_stop), .wdt_pulse(wdt_reset)
  );

  assign irq = flag_s && mode_s.irq_en;
endmodule

// File: rtl/pwt_chk.sv
module pwt_chk (
  input logic clk,
  input logic rst_n,
  input logic wdt_reset,
  input logic run,
  input logic cont,
  input logic flag
);
  AST_WDT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset); // R9
  AST_WDT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> !run); // R9
  AST_WDT_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> !$rose(flag)); // R9
  AST_FLAG_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(run)); // R3
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag) && !$past(cont)) |-> !run); // R4
endmodule

bind prescaled_wdog_timer pwt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_reset(wdt_reset),
  .run(mode_s.run), .cont(mode_s.cont), .flag(flag_s)
);

// File: tb/tb_prescaled_wdog_timer.sv
module tb_prescaled_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [3:0]  bus_be = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq, wdt_reset;

  int checks = 0, fails = 0, pulses = 0;
  string cur_req = "R1";
  logic [1:0] obs = 2'd0;
  bit running = 1'b1;

  always #2 clk = ~clk;

  prescaled_wdog_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wdt_reset(wdt_reset)
  );

  // behavioural reference model
  bit m_ie, m_cont, m_run, m_wdog, m_flag, m_wdtp;
  logic [31:0] m_count;
  int m_pre, m_per;

  function automatic int eff(input logic [15:0] v);
    return (v == 16'd0) ? 65536 : int'(v);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    logic [31:0] r = 32'd0;
    case (a)
      2'd0: begin r[15] = m_wdog; r[12] = m_run; r[10] = m_cont; r[8] = m_ie; end
      2'd1: r = m_count;
      2'd2: r[0] = m_flag;
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ie = 0; m_cont = 0; m_run = 0; m_wdog = 0; m_flag = 0; m_wdtp = 0;
      m_count = 32'd0; m_pre = 65536; m_per = 65536;
    end else begin
      bit wmode, wcnt, wst, kick, rel, expd, eff_exp;
      bit n_ie, n_cont, n_run, n_wdog;
      logic [31:0] nc;
      wmode = bus_we && bus_addr == 2'd0;
      wcnt  = bus_we && bus_addr == 2'd1;
      wst   = bus_we && bus_addr == 2'd2;
      nc = m_count;
      for (int b = 0; b < 4; b++) if (wcnt && bus_be[b]) nc[8*b +: 8] = bus_wdata[8*b +: 8];
      n_ie = m_ie; n_cont = m_cont; n_run = m_run; n_wdog = m_wdog;
      if (wmode && bus_be[1]) begin
        n_ie = bus_wdata[8]; n_cont = bus_wdata[10];
        n_run = bus_wdata[12]; n_wdog = bus_wdata[15];
      end
      kick = wmode && bus_be[3] && bus_wdata[31:24] == 8'hA5 && m_wdog && m_run;
      rel  = wcnt || (n_run && !m_run) || kick;
      expd = m_run && m_pre == 1 && m_per == 1;
      eff_exp = expd && !rel;
      if (rel) begin
        m_pre = eff(nc[31:16]); m_per = eff(nc[15:0]);
      end else if (m_run) begin
        if (m_pre == 1) begin
          m_pre = eff(m_count[31:16]);
          if (m_per == 1) m_per = eff(m_count[15:0]);
          else m_per = m_per - 1;
        end else m_pre = m_pre - 1;
      end
      m_flag = (m_flag && !(wst && bus_be[0] && bus_wdata[0])) || (eff_exp && !m_wdog);
      m_wdtp = eff_exp && m_wdog;
      if (eff_exp && (m_wdog || !m_cont)) n_run = 0;
      m_ie = n_ie; m_cont = n_cont; m_run = n_run; m_wdog = n_wdog;
      m_count = nc;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && running) begin
      chk({31'd0, irq}, {31'd0, m_flag && m_ie}, "irq");
      chk({31'd0, wdt_reset}, {31'd0, m_wdtp}, "wdt_reset");
      chk(bus_rdata, exp_rd(bus_addr), "rdata");
      if (wdt_reset === 1'b1) pulses++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_be = b; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = obs; bus_be = 4'd0; bus_wdata = 32'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look(input logic [1:0] a);
    @(negedge clk);
    obs = a; bus_addr = a;
  endtask

  task automatic tests();
    idle(3); rst_n = 1'b1;
    cur_req = "R1";
    look(0); idle(2); look(1); idle(2); look(2); idle(2); look(3); idle(2);

    cur_req = "R2";
    look(1);
    wr(1, 4'hF, 32'h0003_0005); idle(2);
    wr(1, 4'b0100, 32'h00AB_0000); idle(2);
    look(0);
    wr(0, 4'b0001, 32'hFFFF_FFFF); idle(2);
    wr(0, 4'b0010, 32'h0000_6A00); idle(2);
    wr(0, 4'b0010, 32'h0000_0000); idle(2);

    cur_req = "R4";
    look(2);
    wr(1, 4'hF, 32'h0003_0005);
    wr(0, 4'b0010, 32'h0000_1100); idle(24);
    cur_req = "R8"; look(0); idle(2);
    wr(0, 4'b0010, 32'h0000_0000); idle(2);
    cur_req = "R7"; look(2);
    wr(2, 4'b0001, 32'h0000_0001); idle(3);

    cur_req = "R5";
    wr(1, 4'hF, 32'h0002_0003);
    wr(0, 4'b0010, 32'h0000_1500); idle(30);
    wr(2, 4'b0001, 32'h0000_0001); idle(10);

    cur_req = "R7";
    for (int k = 0; k < 8; k++) begin
      wr(2, 4'b0001, 32'h0000_0001); idle(k);
    end
    wr(2, 4'b0001, 32'h0000_0000); idle(8);

    cur_req = "R6";
    for (int k = 0; k < 9; k++) begin
      wr(1, 4'hF, 32'h0001_0004); idle(k);
      wr(2, 4'b0001, 32'h0000_0001);
    end
    wr(0, 4'b0010, 32'h0000_0000); idle(2);

    cur_req = "R9";
    pulses = 0;
    wr(1, 4'hF, 32'h0002_0004);
    wr(0, 4'b0010, 32'h0000_9000); idle(15);
    checks++;
    if (pulses != 1) begin fails++; $display("FAIL R9 pulses actual=%0d expected=1", pulses); end

    cur_req = "R10";
    pulses = 0;
    wr(0, 4'b0010, 32'h0000_9000);
    for (int k = 0; k < 6; k++) begin idle(4); wr(0, 4'b1000, 32'hA500_0000); end
    checks++;
    if (pulses != 0) begin fails++; $display("FAIL R10 kicked pulses actual=%0d expected=0", pulses); end
    wr(0, 4'b1000, 32'h5A00_0000); idle(12);
    checks++;
    if (pulses != 1) begin fails++; $display("FAIL R10 wrong key pulses actual=%0d expected=1", pulses); end
    wr(0, 4'b0010, 32'h0000_1400);
    for (int k = 0; k < 5; k++) begin idle(3); wr(0, 4'b1000, 32'hA500_0000); end
    wr(2, 4'b0001, 32'h0000_0001); idle(4);

    cur_req = "R11";
    wr(1, 4'hF, 32'h0001_0006);
    wr(2, 4'b0001, 32'h0000_0001); idle(1);
    wr(0, 4'b0010, 32'h0000_0400); idle(20);
    wr(0, 4'b0010, 32'h0000_1400); idle(10);
    wr(0, 4'b0010, 32'h0000_0000);
    wr(2, 4'b0001, 32'h0000_0001); idle(2);

    cur_req = "R3";
    wr(1, 4'hF, 32'h0000_0001);
    wr(0, 4'b0010, 32'h0000_1000); idle(65540);
    wr(2, 4'b0001, 32'h0000_0001);
    wr(1, 4'hF, 32'h0001_0000);
    wr(0, 4'b0010, 32'h0000_1000); idle(65540);
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      tests();
      begin repeat (190000) @(posedge clk); timed_out = 1'b1; end
    join_any
    disable fork;
    running = 1'b0;
    if (timed_out) begin
      checks++; fails++;
      $display("FAIL %s watchdog expired actual=hung expected=done", cur_req);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule